// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

The block gathers eight interrupt request lines and reports the most urgent one to a processor. Software programs it through three byte-wide locations on a simple synchronous bus: a command location, a data location and a trigger-mode location. After reset it waits for a start word. It then runs a short setup sequence whose length depends on two bits of that start word, and after that it accepts operating commands.

Each request line is latched on its rising edge into a request register. A line can instead be placed in level mode, where the request follows the line. A mask register hides selected requests. The lowest-numbered unmasked request wins. The block raises a pending flag and presents a vector equal to a programmed base plus the winning index. An acknowledge strobe marks the winner as in service. End-of-interrupt commands clear in-service bits, either a named one or the lowest one set. A read-select command chooses whether the command location reads back the request register or the in-service register.

Top module: `pic_core`

## Requirements
- R1: After reset the request, in-service, mask and trigger-mode registers are all 0, `intPending` is 0, and a read of the command location (`addr`=0) returns the request register.
- R2: In any state, a write to the command location with bit 4 set is a start word. It is stored, and the next data write (`addr`=1) is taken as the vector base.
- R3: After the base, the sequence expects a cascade word if start bit 1 is 0. Otherwise it expects a mode word if start bit 0 is 1, and otherwise it is ready. After the cascade word it expects a mode word if start bit 0 is 1, and otherwise it is ready. After the mode word it is ready. None of these sequence words alters the mask.
- R4: In the idle state (from reset until the first start word) and in the ready state, a data write loads the mask register. A data read always returns the mask register.
- R5: A rising edge on `irqIn[i]` sets request bit i, visible one cycle later. In edge mode (trigger bit i = 0) the bit stays set after the line falls.
- R6: In level mode (trigger bit i = 1), a low `irqIn[i]` clears request bit i at the next clock edge.
- R7: `intPending` is 1 exactly when some request bit is set whose mask bit is 0. Among such bits the lowest index has the highest priority.
- R8: `vector` equals the stored base plus the winning index, modulo 256.
- R9: An `intAck` pulse while a request is pending sets the winner's in-service bit. The winner's request bit is cleared only in edge mode. An `intAck` pulse with nothing pending changes no register.
- R10: In the ready state, a command byte with bits 7:5 = 011 and bits 4:3 = 00 clears the in-service bit selected by bits 2:0.
- R11: In the ready state, a command byte with bits 7:5 = 001 and bits 4:3 = 00 clears only the lowest-numbered in-service bit that is set.
- R12: In the ready state, a command byte with bits 4:3 = 01 stores a read select. Select low bits 10 make command reads return the request register, 11 return the in-service register, and any other value returns 0.
- R13: A trigger-mode write (`addr`=2) stores the data ANDed with parameter `TRIG_MASK` (default 0xF8). A read of that location returns the stored value.
- R14: Outside the ready state, command writes with bit 4 clear have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Bus write strobe for one cycle |
| addr | input | 2 | 0 command, 1 data, 2 trigger mode |
| wrData | input | 8 | Bus write data |
| rdData | output | 8 | Combinational read data for `addr` |
| irqIn | input | 8 | Interrupt request lines |
| intPending | output | 1 | An unmasked request exists |
| intAck | input | 1 | Acknowledge strobe for one cycle |
| vector | output | 8 | Base plus winning index |

## Verification
A sequencer stuck in the wrong step shows up within one write. A data write lands either in the mask or in a setup word, so reading the mask back right after each step shows which step was taken. A wrong in-service or request bit appears at the command location one cycle after the acknowledge or end-of-interrupt, once the read select is set. A wrong priority or base shows up at `vector` in the same cycle that the requests settle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_TRIG = 2'd2;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_BASE, SEQ_CASC, SEQ_MODE, SEQ_READY
  } seqState_t;

  typedef struct packed {
    logic       loadMask;
    logic       loadBase;
    logic       loadSel;
    logic       loadTrig;
    logic       eoiSpec;
    logic       eoiLow;
    logic [2:0] eoiLevel;
  } dpCtl_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output dpCtl_t     ctl
);
  seqState_t state;
  logic [7:0] startWord;
  logic cmdWr, dataWr, isStart;

  assign cmdWr   = wrEn && (addr == ADDR_CMD);
  assign dataWr  = wrEn && (addr == ADDR_DATA);
  assign isStart = cmdWr && wrData[4];

  always_comb begin
    ctl = '0;
    ctl.eoiLevel = wrData[2:0];
    ctl.loadTrig = wrEn && (addr == ADDR_TRIG);
    if (cmdWr && !wrData[4] && state == SEQ_READY) begin
      if (wrData[3] == 1'b0) begin
        if (wrData[5] && !wrData[7]) begin
          ctl.eoiSpec = wrData[6];
          ctl.eoiLow  = !wrData[6];
        end
      end else begin
        ctl.loadSel = 1'b1;
      end
    end
    if (dataWr) begin
      ctl.loadBase = (state == SEQ_BASE);
      ctl.loadMask = (state == SEQ_IDLE) || (state == SEQ_READY);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      startWord <= '0;
    end else if (isStart) begin
      startWord <= wrData;
      state     <= SEQ_BASE;
    end else if (dataWr) begin
      case (state)
        SEQ_BASE: state <= !startWord[1] ? SEQ_CASC :
                           (startWord[0] ? SEQ_MODE : SEQ_READY);
        SEQ_CASC: state <= startWord[0] ? SEQ_MODE : SEQ_READY;
        SEQ_MODE: state <= SEQ_READY;
        default:  state <= state;
      endcase
    end
  end

  // R2: a start word always leads to the base step
  a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    isStart |=> state == SEQ_BASE);

  // R3: the mode step is entered only from base, cascade or itself
  a_r3_mode_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_MODE) |-> ($past(state) == SEQ_BASE || $past(state) == SEQ_CASC
                             || $past(state) == SEQ_MODE));

  // R14: no command effect outside ready
  a_r14_no_cmd_early: assert property (@(posedge clk) disable iff (!rst_n)
    (state != SEQ_READY) |-> !(ctl.eoiSpec || ctl.eoiLow || ctl.loadSel));
endmodule

// File: rtl/pic_dp.sv
module pic_dp
  import pic_pkg::*;
#(
  parameter int          LINES     = 8,
  parameter logic [7:0]  TRIG_MASK = 8'hF8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dpCtl_t           ctl,
  input  logic [1:0]       addr,
  input  logic [7:0]       wrData,
  output logic [7:0]       rdData,
  input  logic [LINES-1:0] irqIn,
  input  logic             intAck,
  output logic             intPending,
  output logic [7:0]       vector
);
  localparam int IDXW = $clog2(LINES);

  logic [LINES-1:0] irqPrev, reqReg, svcReg, maskReg, trigReg;
  logic [LINES-1:0] reqLive, winHot, rise, lvlDrop, ackClr, eoiClr, svcLow;
  logic [7:0] baseReg, selReg;
  logic [IDXW-1:0] winIdx;
  logic ackTake;

  assign reqLive    = reqReg & ~maskReg;
  assign intPending = |reqLive;
  assign winHot     = reqLive & (~reqLive + 1'b1);
  assign svcLow     = svcReg & (~svcReg + 1'b1);

  always_comb begin
    winIdx = '0;
    for (int i = LINES - 1; i >= 0; i--)
      if (reqLive[i]) winIdx = IDXW'(i);
  end

  assign vector  = baseReg + 8'(winIdx);
  assign ackTake = intAck && intPending;
  assign rise    = irqIn & ~irqPrev;
  assign lvlDrop = trigReg & ~irqIn;
  assign ackClr  = ackTake ? (winHot & ~trigReg) : '0;

  always_comb begin
    eoiClr = '0;
    if (ctl.eoiSpec) eoiClr[ctl.eoiLevel] = 1'b1;
    else if (ctl.eoiLow) eoiClr = svcLow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irqPrev <= '0;
      reqReg  <= '0;
      svcReg  <= '0;
      maskReg <= '0;
      trigReg <= '0;
      baseReg <= '0;
      selReg  <= 8'h02;
    end else begin
      irqPrev <= irqIn;
      reqReg  <= (reqReg & ~lvlDrop & ~ackClr) | rise;
      svcReg  <= (svcReg & ~eoiClr) | (ackTake ? winHot : '0);
      if (ctl.loadMask) maskReg <= wrData[LINES-1:0];
      if (ctl.loadTrig) trigReg <= wrData[LINES-1:0] & TRIG_MASK[LINES-1:0];
      if (ctl.loadBase) baseReg <= wrData;
      if (ctl.loadSel)  selReg  <= wrData;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_CMD:  if (selReg[1:0] == 2'b10) rdData = 8'(reqReg);
                 else if (selReg[1:0] == 2'b11) rdData = 8'(svcReg);
      ADDR_DATA: rdData = 8'(maskReg);
      ADDR_TRIG: rdData = 8'(trigReg);
      default:   rdData = '0;
    endcase
  end

  // R9: an accepted acknowledge marks its winner in service
  a_r9_ack_sets_svc: assert property (@(posedge clk) disable iff (!rst_n)
    (ackTake && !ctl.eoiSpec && !ctl.eoiLow) |=> (svcReg & $past(winHot)) != '0);

  // R10: a specific end clears the named bit
  a_r10_spec_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.eoiSpec && !ackTake) |=> !svcReg[$past(ctl.eoiLevel)]);

  // R6: low level-mode lines drop their requests
  a_r6_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ((trigReg & ~irqIn) != '0) |=> (reqReg & $past(trigReg & ~irqIn)) == '0);

  // R13: trigger writes keep only writable bits
  a_r13_trig_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.loadTrig |=> trigReg == ($past(wrData[LINES-1:0]) & TRIG_MASK[LINES-1:0]));
endmodule

// File: rtl/pic_core.sv
module pic_core
  import pic_pkg::*;
#(
  parameter logic [7:0] TRIG_MASK = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] irqIn,
  output logic       intPending,
  input  logic       intAck,
  output logic [7:0] vector
);
  dpCtl_t ctl;

  pic_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .ctl(ctl)
  );

  pic_dp #(.LINES(8), .TRIG_MASK(TRIG_MASK)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irqIn(irqIn), .intAck(intAck),
    .intPending(intPending), .vector(vector)
  );
endmodule

// File: tb/pic_core_test.sv
`timescale 1ns/1ps
module pic_core_test;
  logic clk = 0, rst_n = 0, wrEn = 0, intAck = 0;
  logic [1:0] addr = 0;
  logic [7:0] wrData = 0, irqIn = 0;
  logic [7:0] rdData, vector;
  logic intPending;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  pic_core uut (.*);

  always #2 clk = ~clk;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); wrEn = 1; addr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdData;
  endtask

  task automatic readReq(output logic [7:0] d);
    wr(2'd0, 8'h0A); rd(2'd0, d);
  endtask

  task automatic readSvc(output logic [7:0] d);
    wr(2'd0, 8'h0B); rd(2'd0, d);
  endtask

  task automatic ack(output logic [7:0] v);
    @(negedge clk); intAck = 1; #1; v = vector;
    @(negedge clk); intAck = 0;
  endtask

  task automatic setIrq(logic [7:0] v);
    @(negedge clk); irqIn = v; @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(2'd0, d); check("R1 req", d, 8'h00);
    rd(2'd1, d); check("R1 mask", d, 8'h00);
    rd(2'd2, d); check("R1 trig", d, 8'h00);
    check("R1 pending", {7'd0, intPending}, 8'h00);
    wr(2'd1, 8'h55); rd(2'd1, d); check("R4 idle mask", d, 8'h55);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_init;
    logic [7:0] d;
    wr(2'd0, 8'h12); wr(2'd1, 8'h40);
    wr(2'd1, 8'hAA); rd(2'd1, d); check("R3 single no-mode ready", d, 8'hAA);
    wr(2'd0, 8'h13); wr(2'd1, 8'h50); wr(2'd1, 8'h0F);
    rd(2'd1, d); check("R2 mode word not mask", d, 8'hAA);
    wr(2'd1, 8'h00); rd(2'd1, d); check("R3 after mode ready", d, 8'h00);
    wr(2'd0, 8'h11); wr(2'd1, 8'h60); wr(2'd1, 8'h04); wr(2'd1, 8'h01);
    rd(2'd1, d); check("R3 cascade+mode path", d, 8'h00);
    wr(2'd1, 8'h03); rd(2'd1, d); check("R4 ready mask", d, 8'h03);
    wr(2'd0, 8'h10);
    wr(2'd0, 8'h0B);  // R14: ignored, not ready
    wr(2'd1, 8'h20); wr(2'd1, 8'h04);
    wr(2'd1, 8'h00); rd(2'd1, d); check("R3 cascade no-mode ready", d, 8'h00);
  endtask

  task automatic t_priority;
    logic [7:0] d;
    setIrq(8'h28);
    check("R7 pending", {7'd0, intPending}, 8'h01);
    check("R8 vector", vector, 8'h23);
    rd(2'd0, d); check("R14 select kept", d, 8'h28);
    wr(2'd1, 8'h08); #1; check("R7 masked winner", vector, 8'h25);
    wr(2'd1, 8'h28); #1; check("R7 all masked", {7'd0, intPending}, 8'h00);
    wr(2'd1, 8'h00);
  endtask

  task automatic t_ack_edge;
    logic [7:0] d, v;
    ack(v); check("R9 ack vector", v, 8'h23);
    readSvc(d); check("R9 svc set", d, 8'h08);
    readReq(d); check("R9 edge req cleared", d, 8'h20);
    setIrq(8'h00);
    readReq(d); check("R5 edge held", d, 8'h20);
    ack(v); readSvc(d); check("R9 second ack", d, 8'h28);
    check("R9 none pending", {7'd0, intPending}, 8'h00);
    ack(v); readSvc(d); check("R9 idle ack no effect", d, 8'h28);
  endtask

  task automatic t_eoi;
    logic [7:0] d, v;
    wr(2'd0, 8'h20); readSvc(d); check("R11 lowest cleared", d, 8'h20);
    wr(2'd0, 8'h65); readSvc(d); check("R10 specific 5", d, 8'h00);
    setIrq(8'h06); ack(v); ack(v);
    readSvc(d); check("R9 two acks", d, 8'h06);
    wr(2'd0, 8'h62); readSvc(d); check("R10 specific 2", d, 8'h02);
    wr(2'd0, 8'h20); readSvc(d); check("R11 last cleared", d, 8'h00);
    setIrq(8'h00);
    wr(2'd0, 8'h08); rd(2'd0, d); check("R12 select 00 reads 0", d, 8'h00);
  endtask

  task automatic t_level;
    logic [7:0] d, v;
    wr(2'd2, 8'hFF); rd(2'd2, d); check("R13 mask FF", d, 8'hF8);
    wr(2'd2, 8'h0F); rd(2'd2, d); check("R13 mask 0F", d, 8'h08);
    wr(2'd2, 8'hF8);
    setIrq(8'h10);
    ack(v); check("R8 level vector", v, 8'h24);
    readReq(d); check("R9 level req kept", d, 8'h10);
    readSvc(d); check("R9 level svc", d, 8'h10);
    setIrq(8'h00);
    readReq(d); check("R6 level dropped", d, 8'h00);
    wr(2'd0, 8'h20);
    wr(2'd0, 8'h12); wr(2'd1, 8'hFE);
    setIrq(8'h10);
    check("R8 wrap", vector, 8'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_init; t_priority; t_ack_edge; t_eoi; t_level;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule